// File: doc/BRIEF.md
# Posted Interrupt Clear/Post Register

This block holds the pending state of six interrupt sources: one wakeup source and five endpoint sources. A one-cycle pulse on a source's hardware event input marks that source as pending. The pending vector goes straight to a downstream priority controller, which is not part of this block. The controller can also retire a source with a one-cycle acknowledge pulse.

A CPU reaches the register over a single-cycle bus at one fixed address. A read returns the pending bits. The meaning of a write depends on a global software-interrupt mode input. With the mode low, a written 0 withdraws a pending request and a written 1 is ignored. With the mode high, a written 1 raises a request from software and a written 0 is ignored. This lets the same register serve both for clearing requests and for injecting test interrupts.

Top module: `irqpc_reg`

## Requirements
- R1: Synchronous active-high reset clears every pending bit, so `pending` is 0 and a read of the register returns 0x00.
- R2: A read at address 0xDC returns the pending bits in data bits 5..0 and 0 in bits 7 and 6. A read at any other address returns 0x00. The read is combinational in the same cycle.
- R3: A high `hw_event[i]` at a clock edge leaves bit i pending after that edge.
- R4: With `sw_mode` low, a write at 0xDC with data bit i = 0 clears pending bit i at the edge. Data bit i = 1 leaves bit i unchanged.
- R5: With `sw_mode` high, a write at 0xDC with data bit i = 1 sets pending bit i at the edge. Data bit i = 0 leaves bit i unchanged.
- R6: Bit 5 is the wakeup source. Bits 4, 3, 2, 1 and 0 are endpoints 8, 7, 6, 5 and 4. Event, acknowledge and pending index i all name register bit i.
- R7: A set, from a hardware event or a software post, wins over a clear from a software write or an acknowledge in the same cycle. The bit stays pending.
- R8: A high `ack[i]` at a clock edge clears pending bit i, unless a set hits it in the same cycle.
- R9: A write to any address other than 0xDC changes no pending bit. Writes to data bits 7 and 6 are ignored.
- R10: When no set and no clear reaches a bit, it holds its value. `pending` always equals the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_event | input | 6 | Hardware set pulse per source |
| ack | input | 6 | Acknowledge/clear pulse per source |
| sw_mode | input | 1 | Global software-interrupt mode: 0 writes clear, 1 writes post |
| bus_addr | input | 8 | Bus address |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Combinational read data |
| pending | output | 6 | Registered pending vector to the priority controller |

## Verification
On every cycle, the assertions check each cell's edge behaviour: a set lands, a set beats a clear, a lone clear drops the bit, and an idle bit holds. They also check that the read data mirrors the pending bits with zero upper bits. Only the bench scenarios can show the full mode-dependent write decode from the bus side. This covers writes at other addresses, the ignored value in each mode, and the source-to-bit mapping. A behavioural reference model is compared against the outputs every cycle, including a long pseudo-random stretch that mixes all inputs.

// File: rtl/irqpc_pkg.sv
package irqpc_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned SRC_N    = 6;
  localparam logic [ADDR_W-1:0] REG_ADDR = 8'hDC;
  localparam int unsigned WAKE_BIT = 5;
endpackage

// File: rtl/irqpc_bus_decode.sv
module irqpc_bus_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SRC_N  = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hDC
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              sw_mode,
  output logic              sel,
  output logic [SRC_N-1:0]  post_vec,
  output logic [SRC_N-1:0]  clear_vec
);
  localparam int unsigned PAD_W = DATA_W - SRC_N;

  logic             wr_hit;
  logic [SRC_N-1:0] wbits;
  logic             unused_hi;

  assign sel       = (bus_addr == REG_ADDR);
  assign wr_hit    = sel & bus_we;
  assign wbits     = bus_wdata[SRC_N-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:DATA_W-PAD_W];

  always_comb begin
    post_vec  = '0;
    clear_vec = '0;
    if (wr_hit) begin
      if (sw_mode) post_vec  = wbits;
      else         clear_vec = ~wbits;
    end
  end
endmodule

// File: rtl/irqpc_pend_cell.sv
module irqpc_pend_cell (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic hw_ack,
  input  logic sw_post,
  input  logic sw_clear,
  output logic pend
);
  logic set_any;
  logic clr_any;

  assign set_any = hw_set | sw_post;
  assign clr_any = sw_clear | hw_ack;

  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (set_any) pend <= 1'b1;
    else if (clr_any) pend <= 1'b0;
  end

  assert_hw_set_R3: assert property (@(posedge clk) disable iff (rst)
    hw_set |=> pend);
  assert_sw_post_R5: assert property (@(posedge clk) disable iff (rst)
    sw_post |=> pend);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (hw_set && (sw_clear || hw_ack)) |=> pend);
  assert_sw_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (sw_clear && !hw_set && !sw_post) |=> !pend);
  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (hw_ack && !hw_set && !sw_post) |=> !pend);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!hw_set && !sw_post && !sw_clear && !hw_ack) |=> $stable(pend));
endmodule

// File: rtl/irqpc_read_mux.sv
module irqpc_read_mux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SRC_N  = 6
) (
  input  logic              sel,
  input  logic [SRC_N-1:0]  pend_vec,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - SRC_N;

  always_comb begin
    rdata = '0;
    if (sel) rdata = {{PAD_W{1'b0}}, pend_vec};
  end
endmodule

// File: rtl/irqpc_reg.sv
module irqpc_reg
  import irqpc_pkg::*;
#(
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_SRC_N  = SRC_N,
  parameter logic [P_ADDR_W-1:0] P_REG_ADDR = REG_ADDR
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [P_SRC_N-1:0]  hw_event,
  input  logic [P_SRC_N-1:0]  ack,
  input  logic                sw_mode,
  input  logic [P_ADDR_W-1:0] bus_addr,
  input  logic                bus_we,
  input  logic [P_DATA_W-1:0] bus_wdata,
  output logic [P_DATA_W-1:0] bus_rdata,
  output logic [P_SRC_N-1:0]  pending
);
  logic               sel;
  logic [P_SRC_N-1:0] post_vec;
  logic [P_SRC_N-1:0] clear_vec;

  irqpc_bus_decode #(
    .ADDR_W(P_ADDR_W), .DATA_W(P_DATA_W), .SRC_N(P_SRC_N), .REG_ADDR(P_REG_ADDR)
  ) u_dec (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .sw_mode  (sw_mode),
    .sel      (sel),
    .post_vec (post_vec),
    .clear_vec(clear_vec)
  );

  // One cell per source; bit index i is source i (R6)
  for (genvar i = 0; i < P_SRC_N; i++) begin : g_cell
    irqpc_pend_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .hw_set  (hw_event[i]),
      .hw_ack  (ack[i]),
      .sw_post (post_vec[i]),
      .sw_clear(clear_vec[i]),
      .pend    (pending[i])
    );
  end

  irqpc_read_mux #(.DATA_W(P_DATA_W), .SRC_N(P_SRC_N)) u_rd (
    .sel     (sel),
    .pend_vec(pending),
    .rdata   (bus_rdata)
  );

  assert_read_mirror_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == P_REG_ADDR) |-> (bus_rdata[P_SRC_N-1:0] == pending));
  assert_read_upper_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[P_DATA_W-1:P_SRC_N] == '0);
  assert_read_other_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != P_REG_ADDR) |-> (bus_rdata == '0));
  assert_foreign_write_R9: assert property (@(posedge clk) disable iff (rst)
    ((bus_addr != P_REG_ADDR) && hw_event == '0 && ack == '0) |=> $stable(pending));
endmodule

// File: tb/irqpc_reg_test.sv
`timescale 1ns/1ps
module irqpc_reg_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] hw_event = '0;
  logic [5:0] ack = '0;
  logic       sw_mode = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pending;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  int model = 0;

  always #2 clk = ~clk;

  irqpc_reg uut (
    .clk(clk), .rst(rst), .hw_event(hw_event), .ack(ack), .sw_mode(sw_mode),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pending(pending)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int read_exp(logic [7:0] a);
    return (a == 8'hDC) ? model : 0;
  endfunction

  function automatic int next_model(logic [5:0] ev, logic [5:0] ak, logic md,
                                    logic [7:0] a, logic we, logic [7:0] wd);
    int n = model;
    bit hit = (a == 8'hDC) && we;
    for (int i = 0; i < 6; i++) begin
      bit s = ev[i] || (hit && md && wd[i]);
      bit c = ak[i] || (hit && !md && !wd[i]);
      if (s) n = n | (1 << i);
      else if (c) n = n & ~(1 << i);
    end
    return n;
  endfunction

  // One clock: drive after negedge, check read before edge, check pending after
  task automatic cyc(string req, logic [5:0] ev, logic [5:0] ak, logic md,
                     logic [7:0] a, logic we, logic [7:0] wd);
    int nm;
    hw_event = ev; ack = ak; sw_mode = md;
    bus_addr = a; bus_we = we; bus_wdata = wd;
    #1;
    check(req, int'(bus_rdata), read_exp(a));
    nm = next_model(ev, ak, md, a, we, wd);
    @(posedge clk);
    @(negedge clk);
    model = nm;
    check(req, int'(pending), model);
  endtask

  task automatic idle(string req);
    cyc(req, 6'h0, 6'h0, 1'b0, 8'hDC, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model = 0;
    // R1 reset state
    bus_addr = 8'hDC; #1;
    check("R1", int'(pending), 0);
    check("R1", int'(bus_rdata), 0);
    // R3/R6 each source sets its own bit, seen at its read position
    for (int i = 0; i < 6; i++) begin
      cyc("R3", 6'(1 << i), 6'h0, 1'b0, 8'hDC, 1'b0, 8'h00);
      idle("R6");
      check("R6", int'(bus_rdata[i]), 1);
    end
    // R4 mode low: write 0 in bit 2 clears; write 1 keeps
    cyc("R4", 6'h0, 6'h0, 1'b0, 8'hDC, 1'b1, 8'hFB);
    check("R4", int'(pending), 6'h3B);
    cyc("R4", 6'h0, 6'h0, 1'b0, 8'hDC, 1'b1, 8'hFF);
    cyc("R4", 6'h0, 6'h0, 1'b0, 8'hDC, 1'b1, 8'h00);
    check("R4", int'(pending), 0);
    // R5 mode high: write 1 posts wakeup and endpoint 4
    cyc("R5", 6'h0, 6'h0, 1'b1, 8'hDC, 1'b1, 8'h21);
    check("R5", int'(pending), 6'h21);
    cyc("R5", 6'h0, 6'h0, 1'b1, 8'hDC, 1'b1, 8'h00);
    check("R5", int'(pending), 6'h21);
    // R9 foreign address and upper data bits
    cyc("R9", 6'h0, 6'h0, 1'b1, 8'hDD, 1'b1, 8'hFF);
    cyc("R9", 6'h0, 6'h0, 1'b0, 8'h5C, 1'b1, 8'h00);
    check("R9", int'(pending), 6'h21);
    cyc("R9", 6'h0, 6'h0, 1'b1, 8'hDC, 1'b1, 8'hC0);
    idle("R2");
    check("R2", int'(bus_rdata), 8'h21);
    cyc("R2", 6'h0, 6'h0, 1'b0, 8'h00, 1'b0, 8'h00);
    // R7 event beats software clear and ack in the same cycle
    cyc("R7", 6'h21, 6'h0, 1'b0, 8'hDC, 1'b1, 8'h00);
    check("R7", int'(pending), 6'h21);
    cyc("R7", 6'h01, 6'h01, 1'b0, 8'hDC, 1'b0, 8'h00);
    check("R7", int'(pending), 6'h21);
    cyc("R7", 6'h0, 6'h20, 1'b1, 8'hDC, 1'b1, 8'h20);
    check("R7", int'(pending), 6'h21);
    // R8 ack clears
    cyc("R8", 6'h0, 6'h20, 1'b0, 8'hDC, 1'b0, 8'h00);
    check("R8", int'(pending), 6'h01);
    // R10 hold when idle
    repeat (3) idle("R10");
    check("R10", int'(pending), 6'h01);
    // R10 mixed pseudo-random traffic against the model
    begin
      logic [31:0] lf = 32'h1D2C3B4A;
      for (int k = 0; k < 400; k++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        cyc("R10", lf[5:0] & lf[11:6], lf[17:12] & lf[23:18], lf[24],
            lf[25] ? 8'hDC : lf[31:24], lf[26], {lf[7:0] ^ lf[31:24]});
      end
    end
    // R1 reset mid-run
    cyc("R1", 6'h3F, 6'h0, 1'b0, 8'hDC, 1'b0, 8'h00);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; model = 0;
    check("R1", int'(pending), 0);
    idle("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule